// File: doc/BRIEF.md
# Hexadecimal Up/Down Counter with Seven-Segment Output

This block holds an 8-bit count and steps it at a slow, fixed rate: ten steps per second, taken from a 24 MHz master clock through an internal prescaler. Three plain control pins drive it:
- an active-low clear that forces the count to zero at any moment;
- a run pin that lets the count advance or freezes it;
- a direction pin that picks counting up or counting down.

The count is shown in hexadecimal on two seven-segment digit outputs, one for each nibble. Two mode pins add optional features. Blanking switches off the upper digit while the count is below 0x10, so only one digit is lit. Bounce mode makes the counter turn around at 0x00 and 0xFF instead of wrapping. All pins are level controls with no data stream, so there is no handshake at the edge of the block.

Top module: `hexcnt_display`

## Requirements
- R1: The prescaler emits one single-cycle step strobe every CLK_HZ/TICK_HZ master clock cycles (2,400,000 at the defaults). The count can change only on a strobe cycle, so it never changes more often than once per CLK_HZ/TICK_HZ cycles.
- R2: While `clr_n` is low, the count is 0x00 at once, with no clock edge needed. Release is synchronised through two flops. The first step comes CLK_HZ/TICK_HZ cycles after the second rising edge that sees `clr_n` high. Clear overrides run, dir and both modes.
- R3: When `run` is low, a strobe leaves the count unchanged.
- R4: With bounce mode off and `run` high, each strobe adds 1 to the count when `dir` is 1 and subtracts 1 when `dir` is 0.
- R5: The segment word is {g,f,e,d,c,b,a}, active high. `seg_hi` shows bits 7:4 of the count and `seg_lo` shows bits 3:0. Digit codes 0 through F map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71 (hex).
- R6: When `blank_lz` is 1 and the count is below 0x10, `seg_hi` is 0x00 (all segments off). `seg_lo` is not affected.
- R7: In bounce mode (`bounce` = 1), an internal direction flag replaces `dir`. The count never wraps. A strobe at 0xFF while going up gives 0xFE and turns the flag to down. A strobe at 0x00 while going down gives 0x01 and turns the flag to up. While bounce mode is off, the flag follows `dir`. The flag is set to up by clear.
- R8: With bounce mode off, counting up from 0xFF gives 0x00 and counting down from 0x00 gives 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (24 MHz nominal) |
| clr_n | input | 1 | Active-low clear, asserted asynchronously |
| run | input | 1 | 1 = advance on strobes, 0 = hold |
| dir | input | 1 | 1 = count up, 0 = count down |
| blank_lz | input | 1 | 1 = blank the upper digit while the count is below 0x10 |
| bounce | input | 1 | 1 = turn around at the count limits instead of wrapping |
| seg_hi | output | 7 | Upper-nibble digit segments {g,f,e,d,c,b,a} |
| seg_lo | output | 7 | Lower-nibble digit segments {g,f,e,d,c,b,a} |

## Verification
The assertions assume that `run`, `dir`, `blank_lz` and `bounce` are synchronous to `clk` and stable around its rising edge. They also assume that `clr_n` is only released well away from an edge, so the two-flop release always takes the same number of cycles. The bench changes every input on the falling clock edge and shrinks the prescaler to four cycles. A model of the count then predicts every step exactly through full sweeps in both directions, across the wrap points, and through the bounce turnarounds.

// File: rtl/hexcnt_pkg.sv
package hexcnt_pkg;
  localparam int CNT_W = 8;
  localparam int NIB_W = 4;
  localparam int SEG_W = 7;
  localparam int DIGITS = CNT_W / NIB_W;
  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [CNT_W-1:0] count_t;
  typedef logic [NIB_W-1:0] nibble_t;
endpackage

// File: rtl/hexcnt_rst_sync.sv
module hexcnt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n = hold_q;
endmodule

// File: rtl/hexcnt_tick_gen.sv
module hexcnt_tick_gen #(
  parameter int DIV = 2400000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else pre_q <= pre_q + PW'(1);
  end

  assign tick = (pre_q == LAST);

  // R1
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LAST);

  generate
    if (DIV > 1) begin : g_single
      // R1
      tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/hexcnt_core.sv
module hexcnt_core
  import hexcnt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   run,
  input  logic   dir,
  input  logic   bounce,
  output count_t count
);
  localparam count_t TOP = {CNT_W{1'b1}};
  localparam count_t ONE = CNT_W'(1);

  count_t cnt_q, cnt_d;
  logic   up_q, up_d;
  logic   step;

  assign step = tick && run;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = bounce ? up_q : dir;
    if (step) begin
      if (bounce) begin
        if (up_q && cnt_q == TOP) begin
          cnt_d = cnt_q - ONE;
          up_d  = 1'b0;
        end else if (!up_q && cnt_q == '0) begin
          cnt_d = ONE;
          up_d  = 1'b1;
        end else begin
          cnt_d = up_q ? cnt_q + ONE : cnt_q - ONE;
        end
      end else begin
        cnt_d = dir ? cnt_q + ONE : cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign count = cnt_q;

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(count));

  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !bounce && dir) |=> count == $past(count) + ONE);

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !bounce && !dir) |=> count == $past(count) - ONE);

  // R8
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !bounce && dir && count == TOP) |=> count == '0);

  // R7
  bounce_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && bounce && count == TOP) |=> count == TOP - ONE);

  // R7
  bounce_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && bounce && count == '0) |=> count == ONE);
endmodule

// File: rtl/hexcnt_seg_dec.sv
module hexcnt_seg_dec
  import hexcnt_pkg::*;
(
  input  nibble_t nib,
  input  logic    blank,
  output seg_t    seg
);
  seg_t lit;

  always_comb begin
    case (nib)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
  end

  assign seg = blank ? '0 : lit;
endmodule

// File: rtl/hexcnt_display.sv
module hexcnt_display
  import hexcnt_pkg::*;
#(
  parameter int CLK_HZ  = 24000000,
  parameter int TICK_HZ = 10
) (
  input  logic       clk,
  input  logic       clr_n,
  input  logic       run,
  input  logic       dir,
  input  logic       blank_lz,
  input  logic       bounce,
  output logic [6:0] seg_hi,
  output logic [6:0] seg_lo
);
  localparam int DIV = CLK_HZ / TICK_HZ;

  logic   rst_n;
  logic   tick;
  count_t count;
  seg_t   segs [DIGITS];

  hexcnt_rst_sync u_sync (
    .clk    (clk),
    .arst_n (clr_n),
    .rst_n  (rst_n)
  );

  hexcnt_tick_gen #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  hexcnt_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .run    (run),
    .dir    (dir),
    .bounce (bounce),
    .count  (count)
  );

  genvar d;
  generate
    for (d = 0; d < DIGITS; d++) begin : g_dig
      logic blank_d;
      if (d == DIGITS - 1) begin : g_top
        assign blank_d = blank_lz && (count[CNT_W-1:NIB_W] == '0);
      end else begin : g_low
        assign blank_d = 1'b0;
      end
      hexcnt_seg_dec u_dec (
        .nib   (count[d*NIB_W +: NIB_W]),
        .blank (blank_d),
        .seg   (segs[d])
      );
    end
  endgenerate

  assign seg_hi = segs[DIGITS-1];
  assign seg_lo = segs[0];

  // R6
  lz_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_lz && count < CNT_W'(16)) |-> seg_hi == '0);

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst_n)
    count == '0);
endmodule

// File: tb/sim_hexcnt_display.sv
module sim_hexcnt_display;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       run = 1'b0;
  logic       dir = 1'b1;
  logic       blank_lz = 1'b0;
  logic       bounce = 1'b0;
  logic [6:0] seg_hi, seg_lo;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_cnt = 8'h00;
  logic       exp_up = 1'b1;

  always #5 clk = ~clk;

  hexcnt_display #(.CLK_HZ(40), .TICK_HZ(10)) u0 (
    .clk(clk), .clr_n(clr_n), .run(run), .dir(dir),
    .blank_lz(blank_lz), .bounce(bounce), .seg_hi(seg_hi), .seg_lo(seg_lo)
  );

  function automatic logic [6:0] seg_of(input logic [3:0] n);
    case (n)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  task automatic check_disp(input string req);
    logic [6:0] eh, el;
    eh = (blank_lz && exp_cnt[7:4] == 4'h0) ? 7'h00 : seg_of(exp_cnt[7:4]);
    el = seg_of(exp_cnt[3:0]);
    checks++;
    if (seg_hi !== eh || seg_lo !== el) begin
      errors++;
      $display("FAIL %s: got hi=%h lo=%h expected hi=%h lo=%h (count %h)",
               req, seg_hi, seg_lo, eh, el, exp_cnt);
    end
  endtask

  task automatic model_step();
    if (!bounce) exp_up = dir;
    if (!run) return;
    if (bounce) begin
      if (exp_up && exp_cnt == 8'hFF) begin exp_cnt = 8'hFE; exp_up = 1'b0; end
      else if (!exp_up && exp_cnt == 8'h00) begin exp_cnt = 8'h01; exp_up = 1'b1; end
      else exp_cnt = exp_up ? exp_cnt + 8'd1 : exp_cnt - 8'd1;
    end else begin
      exp_cnt = dir ? exp_cnt + 8'd1 : exp_cnt - 8'd1;
    end
  endtask

  task automatic step(input string req);
    repeat (DIV) @(posedge clk);
    model_step();
    @(negedge clk);
    check_disp(req);
  endtask

  task automatic release_clear();
    @(negedge clk);
    clr_n = 1'b1;
    exp_cnt = 8'h00;
    exp_up = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state, R5 code for 0
    check_disp("R2");
    blank_lz = 1'b1;
    #1 check_disp("R6");
    blank_lz = 1'b0;

    // R4 R5 R8: full up sweep with wrap
    run = 1'b1; dir = 1'b1;
    release_clear();
    for (int i = 0; i < 260; i++) step("R4/R5/R8 up");

    // R1: no change within DIV-1 cycles after a step
    for (int i = 0; i < 3; i++) begin
      repeat (DIV - 1) @(posedge clk);
      @(negedge clk);
      check_disp("R1");
      repeat (1) @(posedge clk);
      model_step();
      @(negedge clk);
      check_disp("R1");
    end

    // R4 R8: down sweep through 00 -> FF
    @(negedge clk); dir = 1'b0;
    for (int i = 0; i < 270; i++) step("R4/R8 down");

    // R3 hold
    run = 1'b0;
    for (int i = 0; i < 4; i++) step("R3");
    run = 1'b1;
    step("R3");

    // R2 asynchronous clear mid-run, then synchronous release
    @(negedge clk);
    #2 clr_n = 1'b0;
    exp_cnt = 8'h00;
    #1 check_disp("R2");
    dir = 1'b1;
    release_clear();
    for (int i = 0; i < 3; i++) step("R2 restart");

    // R6 blanking over 0x00..0x12
    blank_lz = 1'b1;
    @(negedge clk); clr_n = 1'b0;
    #1 exp_cnt = 8'h00;
    check_disp("R6");
    release_clear();
    for (int i = 0; i < 19; i++) step("R6");
    blank_lz = 1'b0;

    // R7 bounce mode from 0 up through both turnarounds
    bounce = 1'b1;
    @(negedge clk); clr_n = 1'b0;
    release_clear();
    for (int i = 0; i < 530; i++) step("R7");
    // R7: dir ignored in bounce mode
    dir = ~dir;
    for (int i = 0; i < 10; i++) step("R7 dir ignored");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule